// File: doc/BRIEF.md
# Shared-Adder Iterative Multiply/Divide Unit

This block is a sequential arithmetic unit that serves four operations with one adder of width W+1 and one working register of width 2W+1. Signed multiplication uses radix-2 Booth recoding and produces a 2W-bit product. Unsigned division uses the restoring method, with remainder and quotient sharing the working register. Addition and subtraction use the same adder in one step and give an exact, sign-extended 2W-bit result.

A caller presents an opcode and two operands together with a one-cycle `start` pulse. Add and subtract answer in the following cycle. Multiply and divide hold `busy` for W+1 cycles and pulse `done` in the last of those cycles. Operands are captured when an operation is accepted, so the caller may change the inputs while the unit works. The result stays on `result` until the next accepted operation. With the default W of 32, the adder is 33 bits wide, the register is 65 bits wide and an iterative operation takes 33 cycles.

Top module: `muldiv_core`

## Requirements
- R1: Opcode encodings are 3'b001 add, 3'b010 subtract, 3'b110 multiply and 3'b111 divide. With any other code, `start` is ignored: `busy` and `done` stay low and `result` keeps its value.
- R2: An accepted add raises `done` for exactly the next cycle, leaves `busy` low, and sets `result` to the exact signed sum of `op_a` and `op_b` sign-extended to 2W bits.
- R3: An accepted subtract sets `result` to the exact signed difference `op_a - op_b`, sign-extended to 2W bits, with the same timing as R2.
- R4: An accepted multiply sets `result` to the 2W-bit two's-complement product of `op_a` and `op_b`, both read as signed.
- R5: An accepted divide with a nonzero divisor sets `result[W-1:0]` to the unsigned quotient `op_a / op_b` and `result[2W-1:W]` to the remainder `op_a % op_b`.
- R6: After the clock edge that accepts a multiply or divide, `busy` is high for exactly W+1 cycles. `done` is high only in the last of them, and `result` is valid from that cycle on.
- R7: A divide by zero raises `div_zero` in the `done` cycle and gives a quotient of all ones and a remainder equal to the dividend. In every other case `div_zero` is low.
- R8: A `start` pulse received while `busy` is high is ignored, and changes on `op_a`, `op_b` or `opcode` after acceptance do not affect the operation in progress.
- R9: While reset is asserted and right after it is released, `busy`, `done` and `div_zero` are low and `result` is zero.
- R10: While the unit is idle and no operation is accepted, `result` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin the operation named by `opcode` |
| opcode | input | 3 | Operation code (see R1) |
| op_a | input | W | Augend, minuend, multiplicand or dividend |
| op_b | input | W | Addend, subtrahend, multiplier or divisor |
| busy | output | 1 | High while a multiply or divide is running |
| done | output | 1 | One-cycle pulse marking a valid `result` |
| div_zero | output | 1 | Divide-by-zero flag, high together with `done` |
| result | output | 2W | Sum, difference, product, or remainder (upper half) and quotient (lower half) |

## Verification
The bench builds the unit with a 5-bit width and runs all 1024 operand pairs through each of the four operations, so every Booth bit pair sequence and every sign combination meets the product and sum checks. The sweep covers the most negative value, where a narrow partial-product adder would overflow, and the cases where the sum or difference leaves the signed W-bit range, where only correct sign extension gives the right upper half. In the division sweep a zero divisor sits next to divisors below, equal to and above the dividend. During each operation the bench drives inverted operands, which shows whether the unit really captured its inputs. Directed cases send unused opcodes and a second start during a divide; these show whether an ignored request leaves the result and the latency untouched.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  localparam logic [2:0] OPC_ADD = 3'b001;
  localparam logic [2:0] OPC_SUB = 3'b010;
  localparam logic [2:0] OPC_MUL = 3'b110;
  localparam logic [2:0] OPC_DIV = 3'b111;

  typedef enum logic [1:0] {
    MODE_ADD = 2'd0,
    MODE_SUB = 2'd1,
    MODE_MUL = 2'd2,
    MODE_DIV = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    SEL_ZERO  = 2'd0,
    SEL_PLUS  = 2'd1,
    SEL_MINUS = 2'd2
  } addsel_e;

  function automatic logic opc_valid(input logic [2:0] opc);
    return (opc == OPC_ADD) || (opc == OPC_SUB) ||
           (opc == OPC_MUL) || (opc == OPC_DIV);
  endfunction

  function automatic mode_e opc_mode(input logic [2:0] opc);
    case (opc)
      OPC_SUB: return MODE_SUB;
      OPC_MUL: return MODE_MUL;
      OPC_DIV: return MODE_DIV;
      default: return MODE_ADD;
    endcase
  endfunction

  // Booth radix-2 recoding of {current bit, bit shifted out last}
  function automatic addsel_e booth_sel(input logic [1:0] pair);
    case (pair)
      2'b01:   return SEL_PLUS;
      2'b10:   return SEL_MINUS;
      default: return SEL_ZERO;
    endcase
  endfunction

  function automatic logic is_iterative(input mode_e m);
    return (m == MODE_MUL) || (m == MODE_DIV);
  endfunction

endpackage

// File: rtl/md_adder.sv
module md_adder #(
  parameter int N = 33
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic         sub,
  output logic [N-1:0] sum,
  output logic         cout
);
  logic [N-1:0] b_eff;

  // Subtraction: invert the second input and force carry-in high
  assign b_eff = sub ? ~b : b;
  assign {cout, sum} = {1'b0, a} + {1'b0, b_eff} + {{N{1'b0}}, sub};
endmodule

// File: rtl/md_operand_mux.sv
module md_operand_mux
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         busy,
  input  mode_e        run_mode,
  input  logic         idle_sub,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [W-1:0] opnd,
  input  logic [W-1:0] prod_hi,
  input  logic [1:0]   booth_pair,
  input  logic [W-1:0] rem_hi,
  input  logic         rem_in,
  output logic [W:0]   add_a,
  output logic [W:0]   add_b,
  output logic         add_sub
);
  addsel_e sel;

  assign sel = booth_sel(booth_pair);

  always_comb begin
    add_a   = '0;
    add_b   = '0;
    add_sub = 1'b0;
    if (!busy) begin
      // Idle: the adder serves a single-step add or subtract from the ports
      add_a   = {op_a[W-1], op_a};
      add_b   = {op_b[W-1], op_b};
      add_sub = idle_sub;
    end else begin
      case (run_mode)
        MODE_MUL: begin
          add_a = {prod_hi[W-1], prod_hi};
          case (sel)
            SEL_PLUS: begin
              add_b   = {opnd[W-1], opnd};
              add_sub = 1'b0;
            end
            SEL_MINUS: begin
              add_b   = {opnd[W-1], opnd};
              add_sub = 1'b1;
            end
            default: begin
              add_b   = '0;
              add_sub = 1'b0;
            end
          endcase
        end
        MODE_DIV: begin
          // Trial subtraction of the divisor from the shifted partial remainder
          add_a   = {rem_hi, rem_in};
          add_b   = {1'b0, opnd};
          add_sub = 1'b1;
        end
        default: begin
          add_a   = '0;
          add_b   = '0;
          add_sub = 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/md_sequencer.sv
module md_sequencer #(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic accept_iter,
  output logic busy,
  output logic done,
  output logic step_en,
  output logic last_step
);
  localparam int CW = $clog2(W + 1);

  logic [CW-1:0] steps_left;

  assign step_en   = busy && (steps_left != '0);
  assign last_step = busy && (steps_left == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      steps_left <= '0;
      done       <= 1'b0;
    end else begin
      done <= (accept && !accept_iter) || last_step;
      if (accept && accept_iter) begin
        busy       <= 1'b1;
        steps_left <= CW'(W);
      end else if (busy) begin
        if (steps_left != '0) steps_left <= steps_left - CW'(1);
        else                  busy       <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/muldiv_core.sv
module muldiv_core
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [2:0]     opcode,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  output logic           busy,
  output logic           done,
  output logic           div_zero,
  output logic [2*W-1:0] result
);
  localparam int RW = 2 * W + 1;
  localparam int AW = W + 1;

  logic [RW-1:0] work_q;
  logic [W-1:0]  opnd_q;
  mode_e         mode_q;
  logic          dz_q;

  mode_e         req_mode;
  logic          req_ok;
  logic          accept;
  logic          accept_iter;
  logic          step_en;
  logic          last_step;

  logic [AW-1:0] add_a, add_b, add_sum;
  logic          add_sub, add_cout;
  logic [AW-1:0] rem_next;

  assign req_mode    = opc_mode(opcode);
  assign req_ok      = opc_valid(opcode);
  assign accept      = start && !busy && req_ok;
  assign accept_iter = is_iterative(req_mode);

  md_sequencer #(.W(W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .accept_iter(accept_iter),
    .busy       (busy),
    .done       (done),
    .step_en    (step_en),
    .last_step  (last_step)
  );

  md_operand_mux #(.W(W)) u_mux (
    .busy      (busy),
    .run_mode  (mode_q),
    .idle_sub  (req_mode == MODE_SUB),
    .op_a      (op_a),
    .op_b      (op_b),
    .opnd      (opnd_q),
    .prod_hi   (work_q[RW-1:W+1]),
    .booth_pair(work_q[1:0]),
    .rem_hi    (work_q[2*W-1:W]),
    .rem_in    (work_q[W-1]),
    .add_a     (add_a),
    .add_b     (add_b),
    .add_sub   (add_sub)
  );

  md_adder #(.N(AW)) u_add (
    .a   (add_a),
    .b   (add_b),
    .sub (add_sub),
    .sum (add_sum),
    .cout(add_cout)
  );

  // Restoring step: keep the difference only when no borrow occurred
  assign rem_next = add_cout ? add_sum : add_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_q <= '0;
      opnd_q <= '0;
      mode_q <= MODE_ADD;
      dz_q   <= 1'b0;
    end else if (accept) begin
      mode_q <= req_mode;
      case (req_mode)
        MODE_MUL: begin
          work_q <= {{W{1'b0}}, op_a, 1'b0};
          opnd_q <= op_b;
          dz_q   <= 1'b0;
        end
        MODE_DIV: begin
          work_q <= {{AW{1'b0}}, op_a};
          opnd_q <= op_b;
          dz_q   <= (op_b == '0);
        end
        default: begin
          work_q <= {1'b0, {(W-1){add_sum[W]}}, add_sum};
          dz_q   <= 1'b0;
        end
      endcase
    end else if (step_en) begin
      if (mode_q == MODE_MUL) begin
        // Arithmetic right shift of {partial product, multiplier, tail bit}
        work_q <= {add_sum, work_q[W:1]};
      end else begin
        // Left shift with the new quotient bit entering at the bottom
        work_q <= {rem_next, work_q[W-2:0], add_cout};
      end
    end
  end

  assign result   = (mode_q == MODE_MUL) ? work_q[RW-1:1] : work_q[2*W-1:0];
  assign div_zero = done && dz_q && (mode_q == MODE_DIV);
endmodule

// File: rtl/muldiv_core_checker.sv
module muldiv_core_checker #(
  parameter int W = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic [2:0]     opcode,
  input logic           busy,
  input logic           done,
  input logic           div_zero,
  input logic [2*W-1:0] result,
  input logic           accept
);
  int unsigned run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_len <= 0;
    else        run_len <= busy ? run_len + 1 : 0;
  end

  a_r1_invalid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !(opcode inside {3'b001, 3'b010, 3'b110, 3'b111}))
      |=> (!done && !busy));

  a_r2_addsub_done: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (opcode inside {3'b001, 3'b010})) |=> (done && !busy));

  a_r6_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len == W + 1));

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && done) |=> !busy);

  a_r8_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  a_r7_dz_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    div_zero |-> done);

  a_r10_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !accept) |=> $stable(result));
endmodule

bind muldiv_core muldiv_core_checker #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .opcode  (opcode),
  .busy    (busy),
  .done    (done),
  .div_zero(div_zero),
  .result  (result),
  .accept  (accept)
);

// File: tb/muldiv_core_test.sv
module muldiv_core_test;
  localparam int W = 5;
  localparam int N = 1 << W;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [2:0]     opcode = 3'b000;
  logic [W-1:0]   op_a = '0;
  logic [W-1:0]   op_b = '0;
  logic           busy, done, div_zero;
  logic [2*W-1:0] result;

  int checks = 0;
  int errors = 0;

  muldiv_core #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .op_a(op_a), .op_b(op_b), .busy(busy), .done(done),
    .div_zero(div_zero), .result(result)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int sval(input logic [W-1:0] v);
    return v[W-1] ? int'(v) - N : int'(v);
  endfunction

  function automatic logic [2*W-1:0] expect_of(input logic [2:0] opc,
                                               input logic [W-1:0] a,
                                               input logic [W-1:0] b);
    int e;
    logic [W-1:0] q, r;
    case (opc)
      3'b001: e = sval(a) + sval(b);
      3'b010: e = sval(a) - sval(b);
      3'b110: e = sval(a) * sval(b);
      default: e = 0;
    endcase
    if (opc == 3'b111) begin
      if (b == '0) begin q = '1; r = a; end
      else begin q = W'(int'(a) / int'(b)); r = W'(int'(a) % int'(b)); end
      return {r, q};
    end
    return e[2*W-1:0];
  endfunction

  // Drive at the falling edge; afterwards operands are scrambled (R8)
  task automatic issue(input logic [2:0] opc, input logic [W-1:0] a,
                       input logic [W-1:0] b);
    @(negedge clk);
    start = 1'b1; opcode = opc; op_a = a; op_b = b;
    @(negedge clk);
    start = 1'b0; opcode = 3'b000; op_a = ~a; op_b = ~b;
  endtask

  task automatic run_op(input logic [2:0] opc, input logic [W-1:0] a,
                        input logic [W-1:0] b);
    logic [2*W-1:0] exp, got;
    logic dzv;
    int dk, bk;
    exp = expect_of(opc, a, b);
    issue(opc, a, b);
    if (opc == 3'b001 || opc == 3'b010) begin
      chk(done && !busy, "R2 done next cycle", {62'd0, done, busy}, 64'h2);
      chk(result == exp, (opc == 3'b001) ? "R2 sum" : "R3 difference",
          64'(result), 64'(exp));
      @(negedge clk);
      chk(!done, "R2 done single", 64'(done), 64'd0);
    end else begin
      dk = 0; bk = 0; got = '0; dzv = 1'b0;
      for (int k = 1; k <= W + 2; k++) begin
        if (busy) bk++;
        if (done) begin dk = k; got = result; dzv = div_zero; end
        if (k < W + 2) @(negedge clk);
      end
      chk(dk == W + 1, "R6 done cycle", 64'(dk), 64'(W + 1));
      chk(bk == W + 1, "R6 busy length", 64'(bk), 64'(W + 1));
      chk(got == exp, (opc == 3'b110) ? "R4 product" : "R5/R8 quotient-remainder",
          64'(got), 64'(exp));
      if (opc == 3'b111)
        chk(dzv == (b == '0), "R7 div_zero flag", 64'(dzv), 64'(b == '0));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [2*W-1:0] held;
    logic [2:0] bad_codes [4];
    int dk;
    bad_codes = '{3'b000, 3'b011, 3'b100, 3'b101};

    // R9: reset state
    @(negedge clk);
    chk(!busy && !done && !div_zero && result == '0, "R9 in reset",
        64'(result), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !div_zero && result == '0, "R9 after release",
        {53'd0, busy, done, div_zero, 7'd0}, 64'd0);

    // R1: unused opcodes are ignored
    run_op(3'b001, 5'd3, 5'd4);
    held = result;
    foreach (bad_codes[i]) begin
      issue(bad_codes[i], 5'd9, 5'd2);
      chk(!done && !busy, "R1 invalid opcode quiet", {62'd0, done, busy}, 64'd0);
      @(negedge clk);
      chk(result == held, "R1 invalid opcode result", 64'(result), 64'(held));
    end

    // R8: a second start during a divide is ignored
    issue(3'b111, 5'd23, 5'd4);
    @(negedge clk);
    start = 1'b1; opcode = 3'b110; op_a = 5'd7; op_b = 5'd9;
    @(negedge clk);
    start = 1'b0; opcode = 3'b000;
    dk = 0;
    for (int k = 3; k <= W + 2; k++) begin
      if (done) begin dk = k; held = result; end
      if (k < W + 2) @(negedge clk);
    end
    chk(dk == W + 1, "R8 latency unchanged", 64'(dk), 64'(W + 1));
    chk(held == {5'd3, 5'd5}, "R8 result of first op", 64'(held), 64'({5'd3, 5'd5}));
    chk(!busy, "R8 no second operation", 64'(busy), 64'd0);

    // R10: result holds while idle with inputs moving
    held = result;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      op_a = W'(k * 7); op_b = W'(k * 3); opcode = 3'(k);
    end
    chk(result == held, "R10 idle hold", 64'(result), 64'(held));

    // Exhaustive sweeps
    for (int a = 0; a < N; a++)
      for (int b = 0; b < N; b++) begin
        run_op(3'b001, W'(a), W'(b));
        run_op(3'b010, W'(a), W'(b));
        run_op(3'b110, W'(a), W'(b));
        run_op(3'b111, W'(a), W'(b));
      end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule